// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Fractional Stop Length

This block turns one character at a time into an asynchronous serial frame on a single output line. A character is handed over through a valid/ready handshake. The frame that follows is a low start bit, then 5 to 8 data bits sent least significant bit first, then an optional parity bit, and finally a high stop period. The stop period can be set in sixteenths of a bit, from one bit up to two bits. A 16x clock-enable pulse paces every bit, so the baud rate generator stays outside the block. The block holds no queue of its own. The character, its length, its parity mode and its stop length are captured when the handshake completes.

A software-driven break command can also hold the line low. A break that is requested during a frame starts only once that frame has ended. A separate release command ends the break. The line is then held high for one full bit time before the next character can be accepted. Two status outputs report the line state. One shows that a frame is being sent. The other shows that the transmitter is idle with nothing in progress.

Top module: `frac_stop_tx`

## Requirements
- R1: After reset, and whenever nothing is in progress, `txd` is high, `empty` is 1, `busy` is 0 and `char_ready` is 1.
- R2: A character is accepted at a clock edge where `char_valid` and `char_ready` are both 1. `busy` is 1 from the next cycle. `char_ready` stays 0 while a frame or a break is in progress.
- R3: Each frame begins with a start bit that holds `txd` low for exactly 16 ticks of `tick16`.
- R4: `len_sel` values 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. The data bits follow the start bit, least significant bit first, and each lasts 16 ticks. Bits of `char_data` above the selected length are not sent.
- R5: `par_sel` selects the parity bit, which follows the data bits and lasts 16 ticks. Value 0 sends no parity bit. Value 1 sends even parity: the data bits and the parity bit together hold an even number of ones. Value 2 sends odd parity. Value 3 sends `par_fixed` as the parity bit.
- R6: The stop period holds `txd` high for 16 + `stop_sel` ticks for `stop_sel` values 0 to 14, and for 32 ticks when `stop_sel` is 15. Code 8 gives 1.5 bits and code 15 gives 2 bits.
- R7: A change to `char_data`, `len_sel`, `par_sel`, `par_fixed` or `stop_sel` after the character has been accepted has no effect on the frame being sent.
- R8: A `brk_start` pulse while idle drives `txd` low from the next cycle. The line stays low until `brk_stop`. No character is accepted during the break.
- R9: A `brk_start` pulse during a frame lets the frame finish with its full stop period. `txd` then goes low in the cycle after `busy` falls.
- R10: After `brk_stop` ends a break, `txd` is high and `empty` is 0 for exactly 16 ticks. Then the block returns to idle.
- R11: If `brk_start` and `brk_stop` arrive in the same cycle, the stop command wins and no break is started.
- R12: `busy` stays 1 from acceptance until the last stop tick. `empty` is never 1 while `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Clock enable at 16 times the bit rate |
| char_data | input | 8 | Character to send |
| char_valid | input | 1 | Character offered |
| char_ready | output | 1 | Character can be taken this cycle |
| len_sel | input | 2 | Data length code (5 + code bits) |
| par_sel | input | 2 | Parity mode: none, even, odd, fixed |
| par_fixed | input | 1 | Parity value used in fixed mode |
| stop_sel | input | 4 | Stop length code in sixteenths beyond one bit |
| brk_start | input | 1 | Request to hold the line low |
| brk_stop | input | 1 | Request to release the line |
| txd | output | 1 | Serial line, high when idle |
| busy | output | 1 | A frame is being sent |
| empty | output | 1 | Idle with nothing in progress |

## Verification
The bench builds the block with the default of 16 ticks per bit. This is the value the stop code is defined for, so every stop code can be checked against the tick count it should produce, including the 1.5-bit and 2-bit points. The tick enable is driven with random gaps, sometimes one tick every cycle. This tests that element lengths are counted in ticks and not in clock cycles. Random characters, lengths, parity modes and stop codes are mixed with directed cases: masked upper bits, both fixed-parity values, a break from idle, a break that arrives during a frame, and simultaneous break commands. Configuration inputs are changed while a frame is being sent.

// File: rtl/frac_stop_tx.sv
module frac_stop_tx #(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  logic [7:0] char_data,
  input  logic       char_valid,
  output logic       char_ready,
  input  logic [1:0] len_sel,
  input  logic [1:0] par_sel,
  input  logic       par_fixed,
  input  logic [3:0] stop_sel,
  input  logic       brk_start,
  input  logic       brk_stop,
  output logic       txd,
  output logic       busy,
  output logic       empty
);
  localparam int CW = $clog2(2 * OSR + 1);
  localparam logic [CW-1:0] BIT_LAST = CW'(OSR - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_BRK, S_GUARD} st_t;

  st_t           st;
  logic [CW-1:0] cnt, stop_last;
  logic [7:0]    sh;
  logic [2:0]    bidx, blast;
  logic          par_on, par_val, brk_req;

  logic [7:0]    mask;
  logic          par_calc, brk_nx, accept, elem_done;
  logic [CW-1:0] lim, stop_calc;

  assign mask      = 8'hFF >> (2'd3 - len_sel);
  assign brk_nx    = (brk_req | brk_start) & ~brk_stop;
  assign char_ready = (st == S_IDLE) && !brk_req;
  assign accept    = char_valid && char_ready;
  assign lim       = (st == S_STOP) ? stop_last : BIT_LAST;
  assign elem_done = tick16 && (cnt == lim);
  assign stop_calc = (stop_sel == 4'd15) ? CW'(2 * OSR - 1)
                                         : CW'(OSR - 1 + (int'(stop_sel) * OSR) / 16);

  always_comb begin
    case (par_sel)
      2'd1:    par_calc = ^(char_data & mask);
      2'd2:    par_calc = ~^(char_data & mask);
      default: par_calc = par_fixed;
    endcase
  end

  assign busy  = (st == S_START) || (st == S_DATA) || (st == S_PAR) || (st == S_STOP);
  assign empty = (st == S_IDLE);
  assign txd   = (st == S_START || st == S_BRK) ? 1'b0 :
                 (st == S_DATA) ? sh[0] :
                 (st == S_PAR)  ? par_val : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      stop_last <= BIT_LAST;
      sh        <= '0;
      bidx      <= '0;
      blast     <= '0;
      par_on    <= 1'b0;
      par_val   <= 1'b0;
      brk_req   <= 1'b0;
    end else begin
      brk_req <= brk_nx;
      if (tick16 && busy || st == S_GUARD && tick16)
        cnt <= elem_done ? '0 : cnt + 1'b1;
      case (st)
        S_IDLE: begin
          cnt <= '0;
          if (accept) begin
            st        <= S_START;
            sh        <= char_data;
            bidx      <= '0;
            blast     <= {1'b1, len_sel};
            par_on    <= (par_sel != 2'd0);
            par_val   <= par_calc;
            stop_last <= stop_calc;
          end else if (brk_nx) begin
            st <= S_BRK;
          end
        end
        S_START: if (elem_done) st <= S_DATA;
        S_DATA: if (elem_done) begin
          if (bidx == blast) st <= par_on ? S_PAR : S_STOP;
          else begin
            bidx <= bidx + 1'b1;
            sh   <= sh >> 1;
          end
        end
        S_PAR: if (elem_done) st <= S_STOP;
        S_STOP, S_GUARD: if (elem_done) st <= brk_nx ? S_BRK : S_IDLE;
        S_BRK: begin
          cnt <= '0;
          if (!brk_nx) st <= S_GUARD;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module frac_stop_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic char_valid,
  input logic char_ready,
  input logic brk_start,
  input logic brk_stop,
  input logic txd,
  input logic busy,
  input logic empty
);
  // R1
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n) empty |-> txd && char_ready);
  // R2
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) char_valid && char_ready |=> busy);
  // R2
  ready_gate_chk: assert property (@(posedge clk) disable iff (!rst_n) busy |-> !char_ready);
  // R3
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> !txd);
  // R8
  brk_begin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    empty && brk_start && !brk_stop && !char_valid |=> !txd && !busy && !empty);
  // R11
  brk_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    empty && brk_start && brk_stop && !char_valid |=> empty && txd);
  // R12
  excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(busy && empty));
endmodule

bind frac_stop_tx frac_stop_tx_chk chk_i (
  .clk(clk), .rst_n(rst_n), .char_valid(char_valid), .char_ready(char_ready),
  .brk_start(brk_start), .brk_stop(brk_stop), .txd(txd), .busy(busy), .empty(empty)
);

// File: tb/frac_stop_tx_tb.sv
module frac_stop_tx_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, tick16 = 0;
  logic [7:0] char_data = 0;
  logic char_valid = 0, par_fixed = 0, brk_start = 0, brk_stop = 0;
  logic [1:0] len_sel = 0, par_sel = 0;
  logic [3:0] stop_sel = 0;
  logic char_ready, txd, busy, empty;
  int gapmod = 1;
  int n_chk = 0, n_bad = 0;
  bit done = 0;
  bit txq[$], bq[$], eq[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  frac_stop_tx dut_i (.*);

  initial forever begin
    @(posedge clk); #1;
    tick16 = ($urandom % gapmod) == 0;
  end

  always @(negedge clk) if (tick16) begin
    txq.push_back(txd); bq.push_back(busy); eq.push_back(empty);
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    chk(0, "R1", "watchdog expired", 0, 1);
    finish_run();
  end

  function automatic int stop_ticks(logic [3:0] c);
    return (c == 4'd15) ? 32 : 16 + int'(c);
  endfunction

  function automatic bit exp_par(logic [7:0] d, int nb, logic [1:0] m, bit f);
    bit x = 0;
    for (int i = 0; i < nb; i++) x ^= d[i];
    if (m == 2'd1) return x;
    if (m == 2'd2) return ~x;
    return f;
  endfunction

  task automatic clear_q();
    txq.delete(); bq.delete(); eq.delete();
  endtask

  task automatic offer(logic [7:0] d, logic [1:0] l, logic [1:0] p, bit f, logic [3:0] s);
    @(posedge clk); #1;
    clear_q();
    char_data = d; len_sel = l; par_sel = p; par_fixed = f; stop_sel = s;
    char_valid = 1;
    forever begin
      @(negedge clk);
      if (char_ready) break;
    end
    @(posedge clk); #1;
    char_valid = 0;
  endtask

  task automatic scramble_cfg();
    char_data = 8'($urandom); len_sel = 2'($urandom); par_sel = 2'($urandom);
    par_fixed = 1'($urandom); stop_sel = 4'($urandom);
  endtask

  task automatic wait_frame_end();
    forever begin
      @(negedge clk);
      if (!busy) break;
    end
  endtask

  task automatic check_frame(logic [7:0] d, logic [1:0] l, logic [1:0] p, bit f, logic [3:0] s);
    bit fr[$];
    int nb = 5 + int'(l);
    int np = (p != 0) ? 1 : 0;
    int st = stop_ticks(s);
    int total = 16 * (1 + nb + np) + st;
    int bad_s = 0, bad_d = 0, bad_p = 0, bad_t = 0;
    bit pb = exp_par(d, nb, p, f);
    foreach (bq[i]) if (bq[i]) fr.push_back(txq[i]);
    for (int i = 0; i < fr.size(); i++) begin
      if (i < 16) begin if (fr[i] != 0) bad_s++; end
      else if (i < 16 * (1 + nb)) begin if (fr[i] != d[(i - 16) / 16]) bad_d++; end
      else if (i < 16 * (1 + nb + np)) begin if (fr[i] != pb) bad_p++; end
      else if (fr[i] != 1) bad_t++;
    end
    chk(bad_s == 0 && fr.size() >= 16, "R3", "start ticks wrong", bad_s, 0);
    chk(bad_d == 0, "R4", "data ticks wrong", bad_d, 0);
    chk(bad_p == 0, "R5", "parity ticks wrong", bad_p, 0);
    chk(bad_t == 0, "R6", "stop ticks low", bad_t, 0);
    chk(fr.size() == total, "R6", "frame tick length", fr.size(), total);
  endtask

  task automatic run_frame(logic [7:0] d, logic [1:0] l, logic [1:0] p, bit f, logic [3:0] s, bit mess);
    offer(d, l, p, f, s);
    chk(busy == 1, "R2", "busy after accept", busy, 1);
    if (mess) scramble_cfg();  // R7: config changes after acceptance
    wait_frame_end();
    check_frame(d, l, p, f, s);
    chk(empty == 1 && txd == 1, "R12", "idle after last stop tick", {empty, txd}, 3);
  endtask

  task automatic pulse_brk(bit a, bit b);
    @(posedge clk); #1;
    brk_start = a; brk_stop = b;
    @(posedge clk); #1;
    brk_start = 0; brk_stop = 0;
  endtask

  task automatic release_and_check_guard();
    int bad = 0, n = 0;
    @(posedge clk); #1;
    brk_stop = 1;
    @(posedge clk); #1;
    brk_stop = 0;
    clear_q();
    forever begin
      @(negedge clk);
      if (empty) break;
    end
    foreach (txq[i]) begin
      if (!eq[i]) begin n++; if (txq[i] != 1) bad++; end
    end
    chk(bad == 0, "R10", "guard line low", bad, 0);
    chk(n == 16, "R10", "guard tick count", n, 16);
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(txd == 1, "R1", "reset txd", txd, 1);
    chk(empty == 1 && busy == 0, "R1", "reset status", {empty, busy}, 2);
    chk(char_ready == 1, "R1", "reset ready", char_ready, 1);

    // directed formats
    run_frame(8'hFF, 2'd0, 2'd1, 0, 4'd0, 0);   // R4 upper bits masked, R5 even
    run_frame(8'hE0, 2'd0, 2'd2, 0, 4'd8, 0);   // R4 5 bits of zeros, R5 odd, R6 1.5
    run_frame(8'hA5, 2'd3, 2'd3, 1, 4'd15, 0);  // R5 fixed 1, R6 two bits
    run_frame(8'h5A, 2'd3, 2'd3, 0, 4'd7, 1);   // R5 fixed 0, R7
    run_frame(8'h3C, 2'd1, 2'd0, 0, 4'd14, 1);  // R5 none

    // random frames with random tick spacing
    for (int k = 0; k < 40; k++) begin
      gapmod = 1 + int'($urandom % 4);
      run_frame(8'($urandom), 2'($urandom), 2'($urandom), 1'($urandom), 4'($urandom), 1'($urandom));
    end
    gapmod = 2;

    // R11 simultaneous commands
    pulse_brk(1, 1);
    @(negedge clk);
    chk(txd == 1 && empty == 1, "R11", "stop wins", {txd, empty}, 3);

    // R8 break from idle
    pulse_brk(1, 0);
    @(negedge clk);
    chk(txd == 0, "R8", "break line low", txd, 0);
    @(posedge clk); #1 char_valid = 1; char_data = 8'h55;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      chk(char_ready == 0 && txd == 0 && busy == 0, "R8", "break hold", {char_ready, txd, busy}, 0);
    end
    @(posedge clk); #1 char_valid = 0;
    release_and_check_guard();

    // R9 break requested mid-frame
    offer(8'h96, 2'd3, 2'd1, 0, 4'd8);
    repeat (20) @(posedge clk);
    #1 brk_start = 1;
    @(posedge clk); #1 brk_start = 0;
    wait_frame_end();
    check_frame(8'h96, 2'd3, 2'd1, 0, 4'd8);
    chk(txd == 0 && empty == 0, "R9", "break after frame", {txd, empty}, 0);
    repeat (30) @(negedge clk);
    chk(txd == 0, "R9", "break still held", txd, 0);
    release_and_check_guard();
    run_frame(8'h81, 2'd2, 2'd2, 0, 4'd3, 0);

    finish_run();
  end
endmodule